// File: doc/BRIEF.md
# Interlaced 4:2:2 Video H/V/F Timing Generator

This block is the timing master for an interleaved 4:2:2 digital video port. It counts pixel clocks within a line and lines within a frame, and from those two counts produces the three timing flags that the reference codes of such a port carry. H marks the horizontal blanking part of a line. V marks the vertical blanking lines. F names the field of an interlaced frame, which has two fields. Each flag drives its own output pin: H on `hsync_h`, V on `blank_v` and F on `vsync_f`. The current line number is also output, so that a downstream code inserter or pixel source can follow the frame.

Two frame standards are supported and chosen by `std_625`. The 525-line standard has 1716 clocks per line. The 625-line standard has 1728 clocks per line. A line is made of four segments, in this order: a 4-clock end-of-active reference slot, horizontal blanking (268 or 280 clocks), a 4-clock start-of-active reference slot, and 1440 active clocks. A 3-bit mode field turns the generator on. With the value 001 it runs as master. With any other value, including 000 for slave operation, it holds its counters at the start of the frame and drives all three flags low.

The horizontal sequencer is a state machine with the states SEG_EAV, SEG_HBLANK, SEG_SAV and SEG_ACTIVE. Each state lasts for the length of its segment, and then the sequencer moves to the next state in the order given. From SEG_ACTIVE it returns to SEG_EAV, and this is the end-of-line transition that advances the line counter. A synchronous reset, or a mode value other than 001, forces the sequencer to SEG_EAV with its segment count at 0.

Top module: `bt656_hvf_gen`

## Requirements
- R1: `hsync_h` (H) is 1 from pixel index 0 of a line (the first end-of-active reference clock) through the last blanking clock, at index 4+BLANK-1. It is 0 from the first start-of-active reference clock, at index 4+BLANK, through the last active clock. BLANK is 268 in 525-line mode and 280 in 625-line mode.
- R2: A line lasts 2×4+BLANK+1440 clocks (1716 or 1728). `line_num` rises by one on the clock after the last pixel of a line.
- R3: `line_num` counts from 1 up to 525 (`std_625`=0) or 625 (`std_625`=1), and then wraps to 1.
- R4: In 525-line mode `blank_v` (V) is 1 on lines 1–19 and 264–282, and 0 on all other lines.
- R5: In 525-line mode `vsync_f` (F) is 1 on lines 1–3 and 266–525, and 0 on lines 4–265.
- R6: In 625-line mode `blank_v` is 1 on lines 1–22, 311–335 and 624–625, and 0 on all other lines.
- R7: In 625-line mode `vsync_f` is 0 on lines 1–312 and 1 on lines 313–625.
- R8: The generator runs only when `mode_sel` is 3'b001. For any other value, `hsync_h`, `blank_v` and `vsync_f` are 0 at once. From the next clock, `line_num` reads 1 and the pixel position is held at 0. When the mode returns to 001, counting restarts at line 1, pixel 0.
- R9: A synchronous reset (`rst`=1) returns the pixel position to 0 and `line_num` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 3 | Timing mode field; 3'b001 enables master generation |
| std_625 | input | 1 | 0 selects 525-line frames, 1 selects 625-line frames |
| hsync_h | output | 1 | H flag, horizontal blanking indicator |
| blank_v | output | 1 | V flag, vertical blanking indicator |
| vsync_f | output | 1 | F flag, field identifier |
| line_num | output | 10 | Current line number, starting at 1 |

## Verification
The generator is run through whole frames in each standard, so every line boundary where V or F changes is reached. Points just before and just after each boundary are compared, which separates an off-by-one in the line compare from a wrong interval. Within a line, the pixel positions on either side of the blanking-to-reference edge and at the last active clock separate errors in the H edge from errors in line length. The mode field is also driven to 000 and to another non-master value, mid-frame resets are applied, and the counters run through the 525-to-1 wrap. Together these show the hold behaviour, the restart point and the frame length, each apart from the other two.

// File: rtl/bt656_tim_pkg.sv
package bt656_tim_pkg;

    localparam int LINE_W = 10;

    localparam logic [LINE_W-1:0] LINES_525 = 10'd525;
    localparam logic [LINE_W-1:0] LINES_625 = 10'd625;

    localparam logic [2:0] MODE_MASTER = 3'b001;

    typedef enum logic [1:0] {
        SEG_EAV    = 2'd0,
        SEG_HBLANK = 2'd1,
        SEG_SAV    = 2'd2,
        SEG_ACTIVE = 2'd3
    } seg_e;

endpackage

// File: rtl/tim_hseq.sv
module tim_hseq
    import bt656_tim_pkg::*;
#(
    parameter int ACTIVE_CLKS = 1440,
    parameter int REF_CLKS    = 4,
    parameter int BLANK_525   = 268,
    parameter int BLANK_625   = 280
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic std625,
    output logic h_flag,
    output logic eol
);

    localparam int MAX_BLANK = (BLANK_625 > BLANK_525) ? BLANK_625 : BLANK_525;
    localparam int MAX_A     = (ACTIVE_CLKS > REF_CLKS) ? ACTIVE_CLKS : REF_CLKS;
    localparam int MAX_SEG   = (MAX_A > MAX_BLANK) ? MAX_A : MAX_BLANK;
    localparam int CW        = $clog2(MAX_SEG + 1);

    localparam logic [CW-1:0] LEN_REF  = CW'(REF_CLKS);
    localparam logic [CW-1:0] LEN_ACT  = CW'(ACTIVE_CLKS);
    localparam logic [CW-1:0] LEN_B525 = CW'(BLANK_525);
    localparam logic [CW-1:0] LEN_B625 = CW'(BLANK_625);

    seg_e          state;
    seg_e          state_nx;
    logic [CW-1:0] seg_cnt;
    logic [CW-1:0] seg_len;
    logic          seg_last;

    always_comb begin
        unique case (state)
            SEG_EAV:    seg_len = LEN_REF;
            SEG_HBLANK: seg_len = std625 ? LEN_B625 : LEN_B525;
            SEG_SAV:    seg_len = LEN_REF;
            SEG_ACTIVE: seg_len = LEN_ACT;
            default:    seg_len = LEN_REF;
        endcase
    end

    assign seg_last = (seg_cnt >= (seg_len - 1'b1));

    always_comb begin
        state_nx = state;
        if (seg_last) begin
            unique case (state)
                SEG_EAV:    state_nx = SEG_HBLANK;
                SEG_HBLANK: state_nx = SEG_SAV;
                SEG_SAV:    state_nx = SEG_ACTIVE;
                SEG_ACTIVE: state_nx = SEG_EAV;
                default:    state_nx = SEG_EAV;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state   <= SEG_EAV;
            seg_cnt <= '0;
        end else begin
            state   <= state_nx;
            seg_cnt <= seg_last ? '0 : seg_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        h_flag = 1'b0;
        eol    = 1'b0;
        unique case (state)
            SEG_EAV:    h_flag = 1'b1;
            SEG_HBLANK: h_flag = 1'b1;
            SEG_SAV:    h_flag = 1'b0;
            SEG_ACTIVE: eol    = seg_last;
            default:    h_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/tim_line_ctr.sv
module tim_line_ctr
    import bt656_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              std625,
    input  logic              eol,
    output logic [LINE_W-1:0] line_q
);

    logic [LINE_W-1:0] last_line;

    assign last_line = std625 ? LINES_625 : LINES_525;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            line_q <= 10'd1;
        end else if (eol) begin
            line_q <= (line_q >= last_line) ? 10'd1 : line_q + 10'd1;
        end
    end

endmodule

// File: rtl/tim_vf_decode.sv
module tim_vf_decode
    import bt656_tim_pkg::*;
(
    input  logic [LINE_W-1:0] line_q,
    input  logic              std625,
    output logic              v_flag,
    output logic              f_flag
);

    logic v525, f525, v625, f625;

    always_comb begin
        v525 = ((line_q >= 10'd1) && (line_q <= 10'd19)) ||
               ((line_q >= 10'd264) && (line_q <= 10'd282));
        f525 = (line_q <= 10'd3) || (line_q >= 10'd266);
        v625 = (line_q <= 10'd22) ||
               ((line_q >= 10'd311) && (line_q <= 10'd335)) ||
               (line_q >= 10'd624);
        f625 = (line_q >= 10'd313);
        v_flag = std625 ? v625 : v525;
        f_flag = std625 ? f625 : f525;
    end

endmodule

// File: rtl/bt656_hvf_gen.sv
module bt656_hvf_gen
    import bt656_tim_pkg::*;
#(
    parameter int ACTIVE_CLKS = 1440,
    parameter int REF_CLKS    = 4,
    parameter int BLANK_525   = 268,
    parameter int BLANK_625   = 280
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode_sel,
    input  logic        std_625,
    output logic        hsync_h,
    output logic        blank_v,
    output logic        vsync_f,
    output logic [9:0]  line_num
);

    logic run;
    logic h_raw, v_raw, f_raw, eol;
    logic [LINE_W-1:0] line_q;

    assign run = (mode_sel == MODE_MASTER);

    tim_hseq #(
        .ACTIVE_CLKS (ACTIVE_CLKS),
        .REF_CLKS    (REF_CLKS),
        .BLANK_525   (BLANK_525),
        .BLANK_625   (BLANK_625)
    ) u_hseq (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .std625 (std_625),
        .h_flag (h_raw),
        .eol    (eol)
    );

    tim_line_ctr u_line (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .std625 (std_625),
        .eol    (eol),
        .line_q (line_q)
    );

    tim_vf_decode u_vf (
        .line_q (line_q),
        .std625 (std_625),
        .v_flag (v_raw),
        .f_flag (f_raw)
    );

    assign hsync_h  = run & h_raw;
    assign blank_v  = run & v_raw;
    assign vsync_f  = run & f_raw;
    assign line_num = line_q;

endmodule

// File: rtl/bt656_hvf_gen_chk.sv
module bt656_hvf_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_sel,
    input logic       std_625,
    input logic       hsync_h,
    input logic       blank_v,
    input logic       vsync_f,
    input logic [9:0] line_num
);

    logic run;
    assign run = (mode_sel == 3'b001);

    assert_line_range_R3: assert property (@(posedge clk) disable iff (rst)
        (line_num >= 10'd1) && (line_num <= (std_625 ? 10'd625 : 10'd525)));

    assert_line_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(line_num)) |->
            ((line_num == $past(line_num) + 10'd1) || (line_num == 10'd1)));

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!hsync_h && !blank_v && !vsync_f));

    assert_idle_line_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (line_num == 10'd1));

    assert_v_on_line_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(std_625) && !$stable(blank_v)) |->
            !$stable(line_num));

    assert_f_on_line_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(std_625) && !$stable(vsync_f)) |->
            !$stable(line_num));

    assert_h_rise_at_line_R1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $rose(hsync_h)) |-> !$stable(line_num));

endmodule

bind bt656_hvf_gen bt656_hvf_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .std_625  (std_625),
    .hsync_h  (hsync_h),
    .blank_v  (blank_v),
    .vsync_f  (vsync_f),
    .line_num (line_num)
);

// File: tb/tb_bt656_hvf_gen.sv
`timescale 1ns/1ps
module tb_bt656_hvf_gen;

    localparam int ACT  = 16;
    localparam int REF  = 4;
    localparam int B525 = 8;
    localparam int B625 = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b001;
    logic       std_625 = 1'b0;
    logic       hsync_h, blank_v, vsync_f;
    logic [9:0] line_num;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    bt656_hvf_gen #(.ACTIVE_CLKS(ACT), .REF_CLKS(REF),
                    .BLANK_525(B525), .BLANK_625(B625)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .std_625(std_625),
        .hsync_h(hsync_h), .blank_v(blank_v), .vsync_f(vsync_f),
        .line_num(line_num)
    );

    // Expected behaviour written from the requirements
    function automatic int line_len(bit s);
        return 2*REF + (s ? B625 : B525) + ACT;
    endfunction
    function automatic bit exp_h(int p, bit s);
        return p < (REF + (s ? B625 : B525));                      // R1
    endfunction
    function automatic bit exp_v(int l, bit s);
        if (s) return (l <= 22) || (l >= 311 && l <= 335) || (l >= 624);  // R6
        return (l >= 1 && l <= 19) || (l >= 264 && l <= 282);      // R4
    endfunction
    function automatic bit exp_f(int l, bit s);
        if (s) return l >= 313;                                    // R7
        return (l <= 3) || (l >= 266);                             // R5
    endfunction

    // Reference position model (R2, R3, R8, R9)
    int mp = 0;
    int ml = 1;
    always @(posedge clk) begin
        if (rst || mode_sel != 3'b001) begin
            mp <= 0; ml <= 1;
        end else if (mp == line_len(std_625) - 1) begin
            mp <= 0;
            ml <= (ml >= (std_625 ? 625 : 525)) ? 1 : ml + 1;
        end else begin
            mp <= mp + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (line %0d pix %0d)",
                     tag, act, exp, ml, mp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            bit r;
            r = (mode_sel == 3'b001);
            chk("R1 mon hsync_h", int'(hsync_h), r ? int'(exp_h(mp, std_625)) : 0);
            chk(std_625 ? "R6 mon blank_v" : "R4 mon blank_v", int'(blank_v),
                r ? int'(exp_v(ml, std_625)) : 0);
            chk(std_625 ? "R7 mon vsync_f" : "R5 mon vsync_f", int'(vsync_f),
                r ? int'(exp_f(ml, std_625)) : 0);
            chk("R2 mon line_num", int'(line_num), ml);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(bit s);
        step();
        rst = 1'b1; std_625 = s; mode_sel = 3'b001;
        step();
        rst = 1'b0;
    endtask

    task automatic go_to(int l, int p);
        while (!(ml == l && mp == p)) step();
    endtask

    typedef struct packed {
        logic        s625;
        logic [15:0] ln;
        logic [15:0] px;
        logic        h;
        logic        v;
        logic        f;
    } vec_t;

    // Sorted by standard, then position
    localparam vec_t VECS [27] = '{
        '{1'b0, 16'd1,   16'd0,  1'b1, 1'b1, 1'b1},
        '{1'b0, 16'd3,   16'd31, 1'b0, 1'b1, 1'b1},
        '{1'b0, 16'd4,   16'd0,  1'b1, 1'b1, 1'b0},
        '{1'b0, 16'd19,  16'd20, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'd20,  16'd20, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd100, 16'd11, 1'b1, 1'b0, 1'b0},
        '{1'b0, 16'd100, 16'd12, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd263, 16'd5,  1'b1, 1'b0, 1'b0},
        '{1'b0, 16'd264, 16'd20, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'd265, 16'd31, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'd266, 16'd0,  1'b1, 1'b1, 1'b1},
        '{1'b0, 16'd282, 16'd30, 1'b0, 1'b1, 1'b1},
        '{1'b0, 16'd283, 16'd30, 1'b0, 1'b0, 1'b1},
        '{1'b0, 16'd525, 16'd31, 1'b0, 1'b0, 1'b1},
        '{1'b1, 16'd1,   16'd0,  1'b1, 1'b1, 1'b0},
        '{1'b1, 16'd22,  16'd16, 1'b0, 1'b1, 1'b0},
        '{1'b1, 16'd23,  16'd16, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'd100, 16'd15, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'd100, 16'd16, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'd310, 16'd3,  1'b1, 1'b0, 1'b0},
        '{1'b1, 16'd311, 16'd3,  1'b1, 1'b1, 1'b0},
        '{1'b1, 16'd312, 16'd20, 1'b0, 1'b1, 1'b0},
        '{1'b1, 16'd313, 16'd20, 1'b0, 1'b1, 1'b1},
        '{1'b1, 16'd335, 16'd35, 1'b0, 1'b1, 1'b1},
        '{1'b1, 16'd336, 16'd35, 1'b0, 1'b0, 1'b1},
        '{1'b1, 16'd623, 16'd0,  1'b1, 1'b0, 1'b1},
        '{1'b1, 16'd625, 16'd35, 1'b0, 1'b1, 1'b1}
    };

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit cur_std;
        // R9: reset state, sampled while reset is held
        step(); step();
        @(negedge clk);
        chk("R9 reset line_num", int'(line_num), 1);
        chk("R1 reset hsync_h at pix 0", int'(hsync_h), 1);
        step();
        rst = 1'b0;
        mon_on = 1'b1;
        cur_std = 1'b0;

        // Vector table walk
        foreach (VECS[i]) begin
            int l, p;
            l = int'(VECS[i].ln);
            p = int'(VECS[i].px);
            if (VECS[i].s625 != cur_std || l < ml || (l == ml && p < mp)) begin
                cur_std = VECS[i].s625;
                do_reset(cur_std);
            end
            go_to(l, p);
            @(negedge clk);
            chk("R1 vec hsync_h", int'(hsync_h), int'(VECS[i].h));
            chk(cur_std ? "R6 vec blank_v" : "R4 vec blank_v", int'(blank_v), int'(VECS[i].v));
            chk(cur_std ? "R7 vec vsync_f" : "R5 vec vsync_f", int'(vsync_f), int'(VECS[i].f));
            chk("R2 vec line_num", int'(line_num), l);
        end

        // R3: 625 wrap to line 1
        step();
        @(negedge clk);
        chk("R3 wrap 625 line_num", int'(line_num), 1);
        chk("R6 wrap 625 blank_v", int'(blank_v), 1);

        // R2: exact line length in 525 mode
        do_reset(1'b0);
        repeat (line_len(1'b0) - 1) step();
        @(negedge clk);
        chk("R2 last pixel still line 1", int'(line_num), 1);
        chk("R1 last pixel hsync_h", int'(hsync_h), 0);
        step();
        @(negedge clk);
        chk("R2 next line after 1716-scale length", int'(line_num), 2);
        chk("R1 new line hsync_h", int'(hsync_h), 1);

        // R3: 525 wrap
        go_to(525, line_len(1'b0) - 1);
        step();
        @(negedge clk);
        chk("R3 wrap 525 line_num", int'(line_num), 1);
        chk("R5 wrap 525 vsync_f", int'(vsync_f), 1);

        // R8: slave mode and another non-master value
        go_to(40, 20);
        mode_sel = 3'b000;
        @(negedge clk);
        chk("R8 slave hsync_h", int'(hsync_h), 0);
        chk("R8 slave blank_v", int'(blank_v), 0);
        chk("R8 slave vsync_f", int'(vsync_f), 0);
        repeat (60) step();
        @(negedge clk);
        chk("R8 slave line held at 1", int'(line_num), 1);
        mode_sel = 3'b101;
        repeat (60) step();
        @(negedge clk);
        chk("R8 mode 101 line held", int'(line_num), 1);
        chk("R8 mode 101 hsync_h", int'(hsync_h), 0);
        mode_sel = 3'b001;
        @(negedge clk);
        chk("R8 restart hsync_h pix 0", int'(hsync_h), 1);
        chk("R8 restart vsync_f line 1", int'(vsync_f), 1);
        go_to(2, 0);
        @(negedge clk);
        chk("R8 restart reaches line 2", int'(line_num), 2);

        // R9: reset in mid-frame
        go_to(70, 25);
        rst = 1'b1;
        step();
        rst = 1'b0;
        @(negedge clk);
        chk("R9 mid-run reset line_num", int'(line_num), 1);
        chk("R9 mid-run reset hsync_h", int'(hsync_h), 1);

        step();
        finish_run();
    end

endmodule